// File: doc/BRIEF.md
# SDRAM Address Mapper with Per-Bank Row Tracking

This block sits between a host request port and an SDRAM command generator. Each accepted request carries a flat byte address. The block splits that address into a bank index, a row number and a column number. The data bus is 16 bits wide, so address bit 0 is the byte offset within a word and is discarded.

The block also keeps, for every bank, a flag that says whether a row is open and a register that holds which row it is. Each request is classified against that state. A hit means the requested row is already open. A miss means a different row is open in that bank, so a precharge and then an activate are needed. Empty means the bank has no open row, so only an activate is needed. The classification and the decoded fields are registered and appear one clock after the request.

Two static mode inputs control the block:
- `page_mode` selects where the bank bits sit in the address.
- `close_policy` selects closed-page operation, where the row is closed after every access, or open-page operation, where rows stay open.

A one-cycle `prechg_all` pulse reports a precharge-all event.

Top module: `dram_addr_mapper`

## Requirements
- R1: With `page_mode`=1 and the default widths, the column is `req_addr[10:1]`, the bank is `req_addr[13:11]` (just above the column), and the row is `req_addr[27:14]`.
- R2: With `page_mode`=0 and the default widths, the column is `req_addr[10:1]`, the row is `req_addr[24:11]`, and the bank is `req_addr[27:25]` (just above the row).
- R3: `out_valid` is high in exactly the cycle after a cycle with `req_valid` high. The decoded fields, `out_kind` and `out_close` belong to that request.
- R4: `out_kind` uses these encodings: 0 = empty (the bank has no open row), 1 = hit (the same row is open), 2 = miss (another row is open). The value 3 never appears with `out_valid` high.
- R5: With `close_policy`=0, an accessed row stays open. After a miss, the newly requested row is the open row of that bank.
- R6: With `close_policy`=1, `out_close` is 1 and the accessed bank is closed after the access, so a following access to it reports empty. With `close_policy`=0, `out_close` is 0.
- R7: A cycle with `prechg_all` high closes every bank. This includes a row opened by a request in that same cycle; that request is still classified against the state before the pulse.
- R8: Any change of `page_mode` or `close_policy` closes every bank.
- R9: After reset, `out_valid` is 0 and every bank is closed.
- R10: Banks are tracked independently. An access to one bank does not change the open state of another bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 28 | Flat byte address of the request |
| page_mode | input | 1 | 1: bank bits above the column; 0: bank bits above the row |
| close_policy | input | 1 | 1: close the row after each access; 0: leave rows open |
| prechg_all | input | 1 | One-cycle pulse that closes all banks |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_bank | output | 3 | Decoded bank index |
| out_row | output | 14 | Decoded row number |
| out_col | output | 10 | Decoded column (word) number |
| out_kind | output | 2 | 0 empty, 1 hit, 2 miss |
| out_close | output | 1 | Bank is closed after this access |

## Verification
The assertions assume that `page_mode` and `close_policy` do not change in the same cycle as a request. The properties for a repeated access to the same address also require both mode inputs to be stable across the two cycles involved. The stimulus meets this assumption by spending one idle cycle with the new mode values in place before the first request that uses them. It then issues each request as a single-cycle pulse, so every result can be checked before the next request arrives.

// File: rtl/dram_map_pkg.sv
package dram_map_pkg;

    localparam int unsigned DEF_BANK_BITS = 3;
    localparam int unsigned DEF_ROW_BITS  = 14;
    localparam int unsigned DEF_COL_BITS  = 10;
    localparam int unsigned BYTE_OFS_BITS = 1;

    typedef enum logic [1:0] {
        KIND_EMPTY = 2'd0,
        KIND_HIT   = 2'd1,
        KIND_MISS  = 2'd2
    } access_kind_e;

    function automatic access_kind_e classify(input logic is_open, input logic same_row);
        if (!is_open)
            return KIND_EMPTY;
        else if (same_row)
            return KIND_HIT;
        else
            return KIND_MISS;
    endfunction

endpackage

// File: rtl/dram_addr_split.sv
module dram_addr_split #(
    parameter int unsigned BANK_BITS = dram_map_pkg::DEF_BANK_BITS,
    parameter int unsigned ROW_BITS  = dram_map_pkg::DEF_ROW_BITS,
    parameter int unsigned COL_BITS  = dram_map_pkg::DEF_COL_BITS,
    localparam int unsigned OFS      = dram_map_pkg::BYTE_OFS_BITS,
    localparam int unsigned ADDR_W   = OFS + COL_BITS + BANK_BITS + ROW_BITS
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 page_mode,
    output logic [BANK_BITS-1:0] bank,
    output logic [ROW_BITS-1:0]  row,
    output logic [COL_BITS-1:0]  col
);
    localparam int unsigned COL_LO   = OFS;
    localparam int unsigned ABOVE_C  = OFS + COL_BITS;
    localparam int unsigned ABOVE_R  = OFS + COL_BITS + ROW_BITS;
    localparam int unsigned ABOVE_CB = OFS + COL_BITS + BANK_BITS;

    always_comb begin
        col = addr[COL_LO +: COL_BITS];
        if (page_mode) begin
            bank = addr[ABOVE_C +: BANK_BITS];
            row  = addr[ABOVE_CB +: ROW_BITS];
        end else begin
            row  = addr[ABOVE_C +: ROW_BITS];
            bank = addr[ABOVE_R +: BANK_BITS];
        end
    end
endmodule

// File: rtl/dram_bank_slot.sv
module dram_bank_slot #(
    parameter int unsigned ROW_BITS = dram_map_pkg::DEF_ROW_BITS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear_all,
    input  logic                touch,
    input  logic                keep_open,
    input  logic [ROW_BITS-1:0] row_in,
    output logic                is_open,
    output logic [ROW_BITS-1:0] open_row
);
    always_ff @(posedge clk) begin
        if (rst || clear_all) begin
            is_open <= 1'b0;
        end else if (touch) begin
            is_open <= keep_open;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_row <= '0;
        end else if (touch) begin
            open_row <= row_in;
        end
    end
endmodule

// File: rtl/dram_addr_mapper.sv
module dram_addr_mapper #(
    parameter int unsigned BANK_BITS = dram_map_pkg::DEF_BANK_BITS,
    parameter int unsigned ROW_BITS  = dram_map_pkg::DEF_ROW_BITS,
    parameter int unsigned COL_BITS  = dram_map_pkg::DEF_COL_BITS,
    localparam int unsigned ADDR_W   = dram_map_pkg::BYTE_OFS_BITS + COL_BITS + BANK_BITS + ROW_BITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 page_mode,
    input  logic                 close_policy,
    input  logic                 prechg_all,
    output logic                 out_valid,
    output logic [BANK_BITS-1:0] out_bank,
    output logic [ROW_BITS-1:0]  out_row,
    output logic [COL_BITS-1:0]  out_col,
    output logic [1:0]           out_kind,
    output logic                 out_close
);
    import dram_map_pkg::*;

    localparam int unsigned NUM_BANKS = 1 << BANK_BITS;

    logic [BANK_BITS-1:0] dec_bank;
    logic [ROW_BITS-1:0]  dec_row;
    logic [COL_BITS-1:0]  dec_col;
    logic [1:0]           mode_q;
    logic                 mode_change;
    logic                 clear_all;
    logic [NUM_BANKS-1:0] bank_open;
    logic [ROW_BITS-1:0]  bank_row [NUM_BANKS];
    access_kind_e         kind_now;

    dram_addr_split #(
        .BANK_BITS(BANK_BITS),
        .ROW_BITS (ROW_BITS),
        .COL_BITS (COL_BITS)
    ) u_split (
        .addr     (req_addr),
        .page_mode(page_mode),
        .bank     (dec_bank),
        .row      (dec_row),
        .col      (dec_col)
    );

    always_ff @(posedge clk) begin
        mode_q <= {page_mode, close_policy};
    end

    // The first cycle after reset sees mode_q already loaded, so no spurious clear.
    assign mode_change = (mode_q != {page_mode, close_policy});
    assign clear_all   = prechg_all || mode_change;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        dram_bank_slot #(.ROW_BITS(ROW_BITS)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .clear_all(clear_all),
            .touch    (req_valid && (dec_bank == BANK_BITS'(b))),
            .keep_open(!close_policy),
            .row_in   (dec_row),
            .is_open  (bank_open[b]),
            .open_row (bank_row[b])
        );
    end

    assign kind_now = classify(bank_open[dec_bank], bank_row[dec_bank] == dec_row);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_bank  <= '0;
            out_row   <= '0;
            out_col   <= '0;
            out_kind  <= KIND_EMPTY;
            out_close <= 1'b0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                out_bank  <= dec_bank;
                out_row   <= dec_row;
                out_col   <= dec_col;
                out_kind  <= kind_now;
                out_close <= close_policy;
            end
        end
    end
endmodule

// File: rtl/dram_addr_mapper_checker.sv
module dram_addr_mapper_checker #(
    parameter int unsigned ADDR_W = 28
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              page_mode,
    input logic              close_policy,
    input logic              prechg_all,
    input logic              out_valid,
    input logic [1:0]        out_kind,
    input logic              out_close
);
    assert_valid_follows_R3: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);

    assert_no_spurious_valid_R3: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_valid);

    assert_kind_legal_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_kind != 2'd3);

    assert_close_flag_R6: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_close == $past(close_policy));

    assert_repeat_hits_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !close_policy && !prechg_all && $stable(page_mode) && $stable(close_policy))
        ##1 (req_valid && req_addr == $past(req_addr) && $stable(page_mode) && $stable(close_policy))
        |=> out_kind == 2'd1);

    assert_repeat_empty_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && close_policy)
        ##1 (req_valid && req_addr == $past(req_addr))
        |=> out_kind == 2'd0);

    assert_prechg_clears_R7: assert property (@(posedge clk) disable iff (rst)
        prechg_all ##1 req_valid |=> out_kind == 2'd0);
endmodule

bind dram_addr_mapper dram_addr_mapper_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .page_mode   (page_mode),
    .close_policy(close_policy),
    .prechg_all  (prechg_all),
    .out_valid   (out_valid),
    .out_kind    (out_kind),
    .out_close   (out_close)
);

// File: tb/dram_addr_mapper_test.sv
`timescale 1ns/1ps
module dram_addr_mapper_test;
    localparam int unsigned BB = 3;
    localparam int unsigned RB = 14;
    localparam int unsigned CB = 10;
    localparam int unsigned AW = 1 + CB + BB + RB;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          page_mode = 1'b1;
    logic          close_policy = 1'b0;
    logic          prechg_all = 1'b0;
    logic          out_valid;
    logic [BB-1:0] out_bank;
    logic [RB-1:0] out_row;
    logic [CB-1:0] out_col;
    logic [1:0]    out_kind;
    logic          out_close;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dram_addr_mapper uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .page_mode(page_mode), .close_policy(close_policy), .prechg_all(prechg_all),
        .out_valid(out_valid), .out_bank(out_bank), .out_row(out_row), .out_col(out_col),
        .out_kind(out_kind), .out_close(out_close)
    );

    localparam logic [1:0] K_EMPTY = 2'd0;
    localparam logic [1:0] K_HIT   = 2'd1;
    localparam logic [1:0] K_MISS  = 2'd2;

    typedef struct packed {
        logic          page;
        logic          close;
        logic [BB-1:0] bank;
        logic [RB-1:0] row;
        logic [CB-1:0] col;
        logic [1:0]    kind;
        logic [7:0]    req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 3'd2, 14'd5,     10'd7,    K_EMPTY, 8'd1},
        '{1'b1, 1'b0, 3'd2, 14'd5,     10'd9,    K_HIT,   8'd5},
        '{1'b1, 1'b0, 3'd2, 14'd6,     10'd0,    K_MISS,  8'd4},
        '{1'b1, 1'b0, 3'd2, 14'd6,     10'd1,    K_HIT,   8'd5},
        '{1'b1, 1'b0, 3'd3, 14'd5,     10'd0,    K_EMPTY, 8'd10},
        '{1'b1, 1'b0, 3'd2, 14'd6,     10'd2,    K_HIT,   8'd10},
        '{1'b0, 1'b0, 3'd2, 14'd6,     10'd2,    K_EMPTY, 8'd8},
        '{1'b0, 1'b0, 3'd2, 14'd6,     10'd3,    K_HIT,   8'd2},
        '{1'b0, 1'b1, 3'd2, 14'd6,     10'd3,    K_EMPTY, 8'd8},
        '{1'b0, 1'b1, 3'd2, 14'd6,     10'd3,    K_EMPTY, 8'd6},
        '{1'b0, 1'b1, 3'd7, 14'd16383, 10'd1023, K_EMPTY, 8'd6},
        '{1'b0, 1'b0, 3'd7, 14'd16383, 10'd1023, K_EMPTY, 8'd8},
        '{1'b0, 1'b0, 3'd7, 14'd16383, 10'd0,    K_HIT,   8'd5}
    };

    function automatic logic [AW-1:0] make_addr(input logic pm, input logic [BB-1:0] b,
                                                input logic [RB-1:0] r, input logic [CB-1:0] c,
                                                input logic ofs);
        if (pm) return {r, b, c, ofs};
        else    return {b, r, c, ofs};
    endfunction

    task automatic check(input string req, input logic ok, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive one request for one cycle; result checked half a cycle after the capturing edge.
    task automatic issue(input logic pm, input logic cp, input logic [AW-1:0] a, input logic pa);
        @(negedge clk);
        if (pm != page_mode || cp != close_policy) begin
            page_mode = pm;
            close_policy = cp;
            @(negedge clk);
        end
        req_valid = 1'b1;
        req_addr = a;
        prechg_all = pa;
        @(negedge clk);
        req_valid = 1'b0;
        prechg_all = 1'b0;
    endtask

    task automatic expect_out(input string req, input logic [BB-1:0] b, input logic [RB-1:0] r,
                              input logic [CB-1:0] c, input logic [1:0] k, input logic cl);
        check(req, out_valid == 1'b1, "out_valid", 32'(out_valid), 32'd1);
        check(req, out_bank == b && out_row == r && out_col == c, "fields bank/row/col",
              {out_bank, out_row, out_col}, {b, r, c});
        check(req, out_kind == k, "out_kind", 32'(out_kind), 32'(k));
        check(req, out_close == cl, "out_close", 32'(out_close), 32'(cl));
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        check("R9", out_valid == 1'b0, "out_valid after reset", 32'(out_valid), 32'd0);

        // Table: R1 R2 R4 R5 R6 R8 R10
        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].page, VECS[i].close,
                  make_addr(VECS[i].page, VECS[i].bank, VECS[i].row, VECS[i].col, i[0]), 1'b0);
            expect_out($sformatf("R%0d", VECS[i].req), VECS[i].bank, VECS[i].row,
                       VECS[i].col, VECS[i].kind, VECS[i].close);
        end

        // R3: no result in an idle cycle
        @(negedge clk);
        check("R3", out_valid == 1'b0, "out_valid idle", 32'(out_valid), 32'd0);

        // R9: every bank closed after a fresh reset
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int b = 0; b < 8; b++) begin
            issue(1'b0, 1'b0, make_addr(1'b0, 3'(b), 14'd7, 10'd0, 1'b0), 1'b0);
            check("R9", out_kind == K_EMPTY, "kind after reset", 32'(out_kind), 32'(K_EMPTY));
        end

        // R7: a lone precharge-all pulse closes an open bank
        issue(1'b1, 1'b0, make_addr(1'b1, 3'd1, 14'd10, 10'd0, 1'b0), 1'b0);
        issue(1'b1, 1'b0, make_addr(1'b1, 3'd1, 14'd10, 10'd1, 1'b0), 1'b0);
        check("R5", out_kind == K_HIT, "kind reopen", 32'(out_kind), 32'(K_HIT));
        @(negedge clk);
        prechg_all = 1'b1;
        @(negedge clk);
        prechg_all = 1'b0;
        issue(1'b1, 1'b0, make_addr(1'b1, 3'd1, 14'd10, 10'd2, 1'b0), 1'b0);
        check("R7", out_kind == K_EMPTY, "kind after pulse", 32'(out_kind), 32'(K_EMPTY));

        // R7: pulse together with a request: hit against old state, then bank closed
        issue(1'b1, 1'b0, make_addr(1'b1, 3'd1, 14'd10, 10'd3, 1'b0), 1'b1);
        check("R7", out_kind == K_HIT, "kind same cycle", 32'(out_kind), 32'(K_HIT));
        issue(1'b1, 1'b0, make_addr(1'b1, 3'd1, 14'd10, 10'd4, 1'b0), 1'b0);
        check("R7", out_kind == K_EMPTY, "kind after joint pulse", 32'(out_kind), 32'(K_EMPTY));

        // R1 / R2: single raw address bits land in the stated fields
        issue(1'b1, 1'b0, 28'h000_0800, 1'b0);
        check("R1", out_bank == 3'd1 && out_row == 14'd0 && out_col == 10'd0,
              "bit11 page mode", {out_bank, out_row, out_col}, {3'd1, 14'd0, 10'd0});
        issue(1'b0, 1'b0, 28'h200_0000, 1'b0);
        check("R2", out_bank == 3'd1 && out_row == 14'd0 && out_col == 10'd0,
              "bit25 bank mode", {out_bank, out_row, out_col}, {3'd1, 14'd0, 10'd0});
        issue(1'b0, 1'b0, 28'h000_0802, 1'b0);
        check("R2", out_bank == 3'd0 && out_row == 14'd1 && out_col == 10'd1,
              "bit11 bank mode", {out_bank, out_row, out_col}, {3'd0, 14'd1, 10'd1});

        done = 1'b1;
        summary();
    end
endmodule